// File: doc/BRIEF.md
# APB4 Completer-Port Protocol Watcher

This block sits beside one APB4 completer port and only listens. From the select and enable lines it rebuilds, cycle by cycle, which phase the bus is in: idle, setup or access. For each cycle it then tests the handshake, the signal-stability rules and the strobe rules that a compliant requester must obey. It never drives the bus and never corrects anything.

Each broken rule sets its own bit in a sticky flag vector. A one-cycle strobe marks every cycle in which at least one rule was broken. A clear input wipes the sticky bits. A separate one-cycle output reports a completer error response, and it takes the error line into account only in a cycle that completes a transfer. An integrator places the block next to a peripheral to catch bus misuse during bring-up, or leaves it in silicon as a cheap health monitor.

Verdicts are registered. A rule broken in the cycle that ends at clock edge N shows on `ruleFlags` and `violPulse` right after edge N.

Top module: `apb_rule_watch`

## Requirements
- R1: While `rstN` is low, `ruleFlags`, `violPulse` and `xferErr` are all zero and the phase tracker returns to idle. No check fires during reset.
- R2: If a setup cycle (select high, enable low) is followed by a cycle that does not have both select and enable high, flag bit 0 is set.
- R3: If address, protection, direction, write data or strobe in an access cycle differs from the value held in that transfer's setup cycle, flag bit 1 is set.
- R4: If select is high, direction is read (`busWrite` = 0) and any strobe bit is 1, flag bit 2 is set.
- R5: If an access cycle has ready low and the next cycle does not have both select and enable high, flag bit 3 is set.
- R6: If a completing access (select, enable and ready high) is followed by a cycle with enable high, flag bit 4 is set. A new setup cycle straight after completion is legal and sets nothing.
- R7: If enable is high while select is low, flag bit 5 is set.
- R8: If a transfer spends more than `MAX_WAIT` consecutive access cycles with ready low, flag bit 6 is set on the wait cycle numbered `MAX_WAIT`+1. Exactly `MAX_WAIT` wait cycles set nothing.
- R9: `xferErr` pulses for one cycle after a completing access in which `busErr` is high. At any other time `busErr` has no effect on any output.
- R10: A set flag bit stays set until `clrSticky` is sampled high. In the clearing cycle, a rule broken in that same cycle still leaves its bit set.
- R11: `violPulse` is high for exactly the cycle after each cycle in which at least one rule was broken. It is low otherwise.
- R12: Legal traffic sets no flag bit. Legal traffic covers single writes and reads, back-to-back transfers and transfers with wait cycles up to the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every check samples on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| clrSticky | input | 1 | Clears the sticky flag vector when sampled high |
| busAddr | input | ADDR_W | Observed address |
| busSel | input | 1 | Observed completer select |
| busEnable | input | 1 | Observed enable |
| busWrite | input | 1 | Observed direction, 1 = write |
| busWdata | input | DATA_W | Observed write data |
| busStrb | input | DATA_W/8 | Observed byte strobes |
| busProt | input | 3 | Observed protection attributes |
| busReady | input | 1 | Observed completer ready |
| busErr | input | 1 | Observed completer error response |
| ruleFlags | output | 7 | Sticky violation bits, indexed as in R2 to R8 |
| violPulse | output | 1 | One-cycle strobe after any violating cycle |
| xferErr | output | 1 | One-cycle strobe after a completion with error |

## Verification
The hardest situation to reach from the ports is the wait-limit boundary. A transfer must be held in access for exactly `MAX_WAIT` and then `MAX_WAIT`+1 wait cycles, with every captured field kept steady so that no other rule fires alongside. The bench overrides the limit with a small value and drives both lengths in turn, checking for silence after the last allowed wait and for the flag on the first excess one. A second corner is a violation that lands in the same cycle as a clear. The bench reaches it by asserting the clear together with an enable-without-select cycle.

// File: rtl/apb_watch_pkg.sv
package apb_watch_pkg;

  // Rule indices in the sticky vector (bit positions are part of the contract)
  localparam int NUM_RULES          = 7;
  localparam int RULE_NO_ACCESS     = 0;
  localparam int RULE_UNSTABLE      = 1;
  localparam int RULE_READ_STRB     = 2;
  localparam int RULE_DROPPED       = 3;
  localparam int RULE_EN_AFTER_DONE = 4;
  localparam int RULE_EN_NO_SEL     = 5;
  localparam int RULE_TIMEOUT       = 6;

  // Classification of the previous observed cycle
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_WAIT  = 2'd2,
    PH_DONE  = 2'd3
  } phase_t;

  // Strobes from phase control to the datapath
  typedef struct packed {
    logic capture;    // this cycle is a setup cycle
    logic holdCheck;  // this cycle is a legal access cycle
    logic waitCycle;  // access cycle with ready low
    logic doneCycle;  // access cycle with ready high
  } phaseStrobes_t;

endpackage

// File: rtl/apb_watch_phase.sv
module apb_watch_phase
  import apb_watch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busEnable,
  input  logic                 busReady,
  input  logic                 busWrite,
  input  logic                 strbAny,
  output phaseStrobes_t        strobes,
  output logic [NUM_RULES-1:0] ctlHits
);

  phase_t prevPhase;
  phase_t nextPhase;
  logic   selEn;
  logic   inAccess;

  assign selEn    = busSel && busEnable;
  assign inAccess = selEn && ((prevPhase == PH_SETUP) || (prevPhase == PH_WAIT));

  always_comb begin
    if (busSel && !busEnable) begin
      nextPhase = PH_SETUP;
    end else if (inAccess) begin
      nextPhase = busReady ? PH_DONE : PH_WAIT;
    end else begin
      nextPhase = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPhase <= PH_IDLE;
    end else begin
      prevPhase <= nextPhase;
    end
  end

  always_comb begin
    strobes.capture   = busSel && !busEnable;
    strobes.holdCheck = inAccess;
    strobes.waitCycle = inAccess && !busReady;
    strobes.doneCycle = inAccess && busReady;
  end

  always_comb begin
    ctlHits                     = '0;
    ctlHits[RULE_NO_ACCESS]     = (prevPhase == PH_SETUP) && !selEn;
    ctlHits[RULE_READ_STRB]     = busSel && !busWrite && strbAny;
    ctlHits[RULE_DROPPED]       = (prevPhase == PH_WAIT) && !selEn;
    ctlHits[RULE_EN_AFTER_DONE] = (prevPhase == PH_DONE) && busEnable;
    ctlHits[RULE_EN_NO_SEL]     = busEnable && !busSel;
  end

endmodule

// File: rtl/apb_watch_data.sv
module apb_watch_data
  import apb_watch_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int MAX_WAIT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clrSticky,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [2:0]           busProt,
  input  logic                 busWrite,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [DATA_W/8-1:0]  busStrb,
  input  logic                 busErr,
  input  phaseStrobes_t        strobes,
  input  logic [NUM_RULES-1:0] ctlHits,
  output logic [NUM_RULES-1:0] ruleFlags,
  output logic                 violPulse,
  output logic                 xferErr
);

  localparam int STRB_W = DATA_W / 8;
  localparam int HOLD_W = ADDR_W + 3 + 1 + DATA_W + STRB_W;
  localparam int CNT_W  = $clog2(MAX_WAIT + 2);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_WAIT);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(MAX_WAIT + 1);

  logic [HOLD_W-1:0]    heldFields;
  logic [HOLD_W-1:0]    liveFields;
  logic                 holdMismatch;
  logic [CNT_W-1:0]     waitCnt;
  logic                 timeoutHit;
  logic [NUM_RULES-1:0] allHits;

  assign liveFields = {busAddr, busProt, busWrite, busWdata, busStrb};

  // Field snapshot taken in every setup cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldFields <= '0;
    end else if (strobes.capture) begin
      heldFields <= liveFields;
    end
  end

  assign holdMismatch = strobes.holdCheck && (liveFields != heldFields);

  // Count of earlier consecutive wait cycles, saturating past the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (!strobes.waitCycle) begin
      waitCnt <= '0;
    end else if (waitCnt != CNT_SAT) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign timeoutHit = strobes.waitCycle && (waitCnt == CNT_LIMIT);

  always_comb begin
    allHits                = ctlHits;
    allHits[RULE_UNSTABLE] = ctlHits[RULE_UNSTABLE] | holdMismatch;
    allHits[RULE_TIMEOUT]  = ctlHits[RULE_TIMEOUT] | timeoutHit;
  end

  // Sticky vector: a clear drops old bits, but this cycle's hits survive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ruleFlags <= '0;
      violPulse <= 1'b0;
      xferErr   <= 1'b0;
    end else begin
      ruleFlags <= (clrSticky ? '0 : ruleFlags) | allHits;
      violPulse <= |allHits;
      xferErr   <= strobes.doneCycle && busErr;
    end
  end

endmodule

// File: rtl/apb_rule_watch.sv
module apb_rule_watch
  import apb_watch_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int MAX_WAIT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clrSticky,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busSel,
  input  logic                 busEnable,
  input  logic                 busWrite,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [DATA_W/8-1:0]  busStrb,
  input  logic [2:0]           busProt,
  input  logic                 busReady,
  input  logic                 busErr,
  output logic [NUM_RULES-1:0] ruleFlags,
  output logic                 violPulse,
  output logic                 xferErr
);

  phaseStrobes_t        strobes;
  logic [NUM_RULES-1:0] ctlHits;
  logic                 strbAny;

  assign strbAny = |busStrb;

  apb_watch_phase u_phase (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busEnable (busEnable),
    .busReady  (busReady),
    .busWrite  (busWrite),
    .strbAny   (strbAny),
    .strobes   (strobes),
    .ctlHits   (ctlHits)
  );

  apb_watch_data #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MAX_WAIT (MAX_WAIT)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .clrSticky (clrSticky),
    .busAddr   (busAddr),
    .busProt   (busProt),
    .busWrite  (busWrite),
    .busWdata  (busWdata),
    .busStrb   (busStrb),
    .busErr    (busErr),
    .strobes   (strobes),
    .ctlHits   (ctlHits),
    .ruleFlags (ruleFlags),
    .violPulse (violPulse),
    .xferErr   (xferErr)
  );

endmodule

// File: rtl/apb_watch_props.sv
module apb_watch_props
  import apb_watch_pkg::*;
#(
  parameter int STRB_W = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 clrSticky,
  input logic                 busSel,
  input logic                 busEnable,
  input logic                 busWrite,
  input logic [STRB_W-1:0]    busStrb,
  input logic                 busReady,
  input logic                 busErr,
  input logic [NUM_RULES-1:0] ruleFlags,
  input logic                 violPulse,
  input logic                 xferErr
);

  assert_setup_followup_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busEnable) ##1 !(busSel && busEnable) |=> ruleFlags[RULE_NO_ACCESS]);

  assert_read_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && (busStrb != '0)) |=> ruleFlags[RULE_READ_STRB]);

  assert_enable_no_select_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busEnable && !busSel) |=> (ruleFlags[RULE_EN_NO_SEL] && violPulse));

  assert_err_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    xferErr |-> $past(busErr && busSel && busEnable && busReady));

  assert_clear_effect_R10: assert property (@(posedge clk) disable iff (!rstN)
    clrSticky |=> (violPulse || (ruleFlags == '0)));

  assert_bits_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    !clrSticky |=> ((ruleFlags & $past(ruleFlags)) == $past(ruleFlags)));

  assert_pulse_has_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    violPulse |-> (ruleFlags != '0));

endmodule

bind apb_rule_watch apb_watch_props #(
  .STRB_W (DATA_W / 8)
) u_props (
  .clk       (clk),
  .rstN      (rstN),
  .clrSticky (clrSticky),
  .busSel    (busSel),
  .busEnable (busEnable),
  .busWrite  (busWrite),
  .busStrb   (busStrb),
  .busReady  (busReady),
  .busErr    (busErr),
  .ruleFlags (ruleFlags),
  .violPulse (violPulse),
  .xferErr   (xferErr)
);

// File: tb/sim_apb_rule_watch.sv
`timescale 1ns/1ps
module sim_apb_rule_watch;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = DW / 8;
  localparam int MW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clrSticky = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busSel = 1'b0;
  logic          busEnable = 1'b0;
  logic          busWrite = 1'b0;
  logic [DW-1:0] busWdata = '0;
  logic [SW-1:0] busStrb = '0;
  logic [2:0]    busProt = '0;
  logic          busReady = 1'b0;
  logic          busErr = 1'b0;
  logic [6:0]    ruleFlags;
  logic          violPulse;
  logic          xferErr;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  apb_rule_watch #(.ADDR_W(AW), .DATA_W(DW), .MAX_WAIT(MW)) u0 (
    .clk(clk), .rstN(rstN), .clrSticky(clrSticky), .busAddr(busAddr),
    .busSel(busSel), .busEnable(busEnable), .busWrite(busWrite),
    .busWdata(busWdata), .busStrb(busStrb), .busProt(busProt),
    .busReady(busReady), .busErr(busErr), .ruleFlags(ruleFlags),
    .violPulse(violPulse), .xferErr(xferErr)
  );

  // Drive one bus cycle (called at a falling edge), return at the next falling edge
  task automatic step(input logic s, input logic e, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [SW-1:0] st, input logic r,
                      input logic er, input logic c);
    busSel = s; busEnable = e; busWrite = w; busAddr = a;
    busWdata = d; busStrb = st; busReady = r; busErr = er; clrSticky = c;
    @(negedge clk);
  endtask

  task automatic idle(input logic c);
    step(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b0, c);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic checkFlags(input string req, input logic [6:0] exp, input logic expPulse);
    check(req, {1'b0, ruleFlags}, {1'b0, exp});
    check(req, {7'b0, violPulse}, {7'b0, expPulse});
  endtask

  task automatic clearAll();
    idle(1'b1);
    check("R10 clear", {1'b0, ruleFlags}, 8'h00);
  endtask

  task automatic t_reset();
    check("R1 flags", {1'b0, ruleFlags}, 8'h00);
    check("R1 pulse", {7'b0, violPulse}, 8'h00);
    check("R1 xferErr", {7'b0, xferErr}, 8'h00);
  endtask

  task automatic t_legal();
    step(1, 0, 1, 16'h0010, 32'hA5A5_0001, 4'hF, 0, 0, 0);
    step(1, 1, 1, 16'h0010, 32'hA5A5_0001, 4'hF, 1, 0, 0);
    step(1, 0, 1, 16'h0014, 32'h1234_5678, 4'h3, 0, 0, 0);
    step(1, 1, 1, 16'h0014, 32'h1234_5678, 4'h3, 1, 0, 0);
    step(1, 0, 0, 16'h0020, 32'h0, 4'h0, 0, 0, 0);
    step(1, 1, 0, 16'h0020, 32'h0, 4'h0, 0, 0, 0);
    step(1, 1, 0, 16'h0020, 32'h0, 4'h0, 0, 0, 0);
    step(1, 1, 0, 16'h0020, 32'h0, 4'h0, 1, 0, 0);
    idle(1'b0);
    checkFlags("R12 legal traffic", 7'h00, 1'b0);
  endtask

  task automatic t_err();
    step(1, 0, 1, 16'h0030, 32'h5, 4'h1, 0, 1, 0);
    check("R9 err in setup", {7'b0, xferErr}, 8'h00);
    step(1, 1, 1, 16'h0030, 32'h5, 4'h1, 0, 1, 0);
    check("R9 err in wait", {7'b0, xferErr}, 8'h00);
    step(1, 1, 1, 16'h0030, 32'h5, 4'h1, 1, 1, 0);
    check("R9 err at completion", {7'b0, xferErr}, 8'h01);
    step(0, 0, 0, '0, '0, '0, 1, 1, 0);
    check("R9 err when idle", {7'b0, xferErr}, 8'h00);
    checkFlags("R9 no flags", 7'h00, 1'b0);
  endtask

  task automatic t_no_access();
    step(1, 0, 1, 16'h0040, 32'h9, 4'hF, 0, 0, 0);
    idle(1'b0);
    checkFlags("R2 setup then idle", 7'b000_0001, 1'b1);
    idle(1'b0);
    checkFlags("R11 pulse drops, R10 bit held", 7'b000_0001, 1'b0);
    clearAll();
  endtask

  task automatic t_unstable();
    step(1, 0, 1, 16'h0050, 32'h77, 4'hF, 0, 0, 0);
    step(1, 1, 1, 16'h0054, 32'h77, 4'hF, 1, 0, 0);
    checkFlags("R3 address moved", 7'b000_0010, 1'b1);
    clearAll();
    busProt = 3'b000;
    step(1, 0, 1, 16'h0050, 32'h77, 4'hF, 0, 0, 0);
    busProt = 3'b010;
    step(1, 1, 1, 16'h0050, 32'h77, 4'hF, 1, 0, 0);
    busProt = 3'b000;
    checkFlags("R3 protection moved", 7'b000_0010, 1'b1);
    clearAll();
    step(1, 0, 1, 16'h0050, 32'h77, 4'hF, 0, 0, 0);
    step(1, 1, 1, 16'h0050, 32'h77, 4'hF, 0, 0, 0);
    step(1, 1, 1, 16'h0050, 32'h78, 4'hF, 1, 0, 0);
    checkFlags("R3 data moved in wait", 7'b000_0010, 1'b1);
    clearAll();
  endtask

  task automatic t_read_strb();
    step(1, 0, 0, 16'h0060, 32'h0, 4'h1, 0, 0, 0);
    checkFlags("R4 strobe on read", 7'b000_0100, 1'b1);
    step(1, 1, 0, 16'h0060, 32'h0, 4'h1, 1, 0, 0);
    clearAll();
  endtask

  task automatic t_dropped();
    step(1, 0, 1, 16'h0070, 32'h1, 4'hF, 0, 0, 0);
    step(1, 1, 1, 16'h0070, 32'h1, 4'hF, 0, 0, 0);
    checkFlags("R5 wait cycle legal", 7'h00, 1'b0);
    idle(1'b0);
    checkFlags("R5 transfer dropped", 7'b000_1000, 1'b1);
    clearAll();
  endtask

  task automatic t_after_done();
    step(1, 0, 1, 16'h0080, 32'h2, 4'hF, 0, 0, 0);
    step(1, 1, 1, 16'h0080, 32'h2, 4'hF, 1, 0, 0);
    step(1, 1, 1, 16'h0080, 32'h2, 4'hF, 1, 0, 0);
    checkFlags("R6 enable after completion", 7'b001_0000, 1'b1);
    clearAll();
  endtask

  task automatic t_en_no_sel();
    step(0, 1, 0, '0, '0, '0, 0, 0, 0);
    checkFlags("R7 enable without select", 7'b010_0000, 1'b1);
    step(0, 1, 0, '0, '0, '0, 0, 0, 1);
    checkFlags("R10 hit survives clear", 7'b010_0000, 1'b1);
    clearAll();
  endtask

  task automatic t_timeout();
    step(1, 0, 1, 16'h0090, 32'h3, 4'hF, 0, 0, 0);
    for (int i = 0; i < MW; i++) step(1, 1, 1, 16'h0090, 32'h3, 4'hF, 0, 0, 0);
    step(1, 1, 1, 16'h0090, 32'h3, 4'hF, 1, 0, 0);
    checkFlags("R8 exactly limit waits", 7'h00, 1'b0);
    step(1, 0, 1, 16'h0094, 32'h4, 4'hF, 0, 0, 0);
    for (int i = 0; i < MW; i++) step(1, 1, 1, 16'h0094, 32'h4, 4'hF, 0, 0, 0);
    checkFlags("R8 before excess", 7'h00, 1'b0);
    step(1, 1, 1, 16'h0094, 32'h4, 4'hF, 0, 0, 0);
    checkFlags("R8 excess wait", 7'b100_0000, 1'b1);
    step(1, 1, 1, 16'h0094, 32'h4, 4'hF, 1, 0, 0);
    idle(1'b0);
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    idle(1'b0);
    t_reset();
    t_legal();
    t_err();
    t_no_access();
    t_unstable();
    t_read_strb();
    t_dropped();
    t_after_done();
    t_en_no_sel();
    t_timeout();
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule